// File: doc/BRIEF.md
# Multi-Lane Stereo Serial Audio Transmitter

This block takes 32-bit audio samples from a write port with valid/ready handshaking and sends them out as stereo serial audio on up to `LANES` parallel data lanes. All lanes share one bit clock and one word-select (frame) clock. Each frame is 64 bit periods long: a 32-bit left slot followed by a 32-bit right slot. Every word goes out most significant bit first. Samples arrive interleaved in frame order. Word 0 of a frame is the left sample of lane 0, word 1 is the right sample of lane 0, word 2 is the left sample of lane 1, and so on.

Static control inputs set the following:
- the number of active stereo lanes, written as the count minus one;
- a run enable;
- a data-output enable that is separate from the clocks;
- the word-select polarity;
- for each lane, an enable and an alignment mode. The mode is either the standard one-bit delay after the word-select edge or left-justified with no delay.

A buffer holds incoming words. A stager gathers one complete frame's worth of words ahead of each frame boundary. If a frame is not ready at a boundary, every lane sends zeros for that frame and a sticky underflow flag is raised. Clearing the run enable stops the clocks at once and returns the serial outputs to idle. Samples already buffered are kept.

Top module: `i2s_multilane_tx`

## Requirements
- R1: A 32-bit word is accepted on each clock where `smp_valid` and `smp_ready` are both high. `smp_ready` falls only when `FIFO_DEPTH` words are buffered on top of one fully staged frame. In frame order, word 2l is lane l's left sample and word 2l+1 is its right sample.
- R2: `cfg_lanes_m1` holds the number of active stereo lanes minus one. Each frame consumes 2·(`cfg_lanes_m1`+1) words.
- R3: The bit clock period is 2·`BCLK_HALF` clock cycles. Data and word-select change only as the bit clock falls. Each slot carries 32 bits MSB first, and a frame is 64 bit periods: left slot first, then right slot.
- R4: With `lane_i2s[l]`=1, lane l is delayed by one bit period. The MSB of the left sample appears in the second bit period of the frame, and the LSB of the right sample appears in the first bit period of the next frame. With `lane_i2s[l]`=0, the MSB appears in the first bit period (left-justified).
- R5: `ws` equals `cfg_ws_inv` during the left slot and its inverse during the right slot. While stopped, `ws` rests at the left-slot level.
- R6: `sd[l]` carries data only when `cfg_data_en`, `lane_enable[l]` and l ≤ `cfg_lanes_m1` all hold; otherwise it is 0. The bit clock and `ws` run regardless of `cfg_data_en`.
- R7: With `cfg_enable` high, the bit clock stays low until the first complete frame has been staged. The first frame then begins with its left slot.
- R8: If a frame boundary arrives with no complete frame staged, every lane sends an all-zero frame and `underflow` is set. `underflow` stays set while running and is cleared by reset or by a new start from the stopped state.
- R9: One clock after `cfg_enable` is low, `bclk` is 0, all `sd` are 0 and `ws` is at the left-slot level. Samples already buffered are not discarded.
- R10: After reset, `bclk`, `sd` and `underflow` are 0 and `smp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample word offered |
| smp_data | input | 32 | Sample word |
| smp_ready | output | 1 | Buffer can take a word |
| cfg_enable | input | 1 | Run enable; low stops the serial side |
| cfg_data_en | input | 1 | Serial data output enable |
| cfg_ws_inv | input | 1 | Word-select polarity (left-slot level) |
| cfg_lanes_m1 | input | LW | Active stereo lanes minus one |
| lane_enable | input | LANES | Per-lane output enable |
| lane_i2s | input | LANES | Per-lane mode: 1 one-bit delay, 0 left-justified |
| bclk | output | 1 | Shared bit clock |
| ws | output | 1 | Shared word-select clock |
| sd | output | LANES | Serial data, one bit per lane |
| underflow | output | 1 | Sticky flag: a frame found no staged samples |

## Verification
The bench builds the block with `LANES`=2, `FIFO_DEPTH`=8 and `BCLK_HALF`=1. With these values a frame lasts 128 clocks, so each run can be followed through three data frames into the zero-filled underflow frame. It sweeps the following:
- both lane counts;
- all four combinations of per-lane alignment;
- both word-select polarities;
- gating cases from the data enable and the per-lane enables.

With the small buffer, a full stall is reached after only twelve writes. Every captured frame is compared bit for bit against a sample pattern generated arithmetically in the bench.

// File: rtl/i2sx_pkg.sv
package i2sx_pkg;
  localparam int SMP_W      = 32;
  localparam int FRAME_BITS = 2 * SMP_W;
  localparam int BIT_IW     = $clog2(FRAME_BITS);
endpackage

// File: rtl/i2sx_fifo.sv
module i2sx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          in_ready,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_wr;

  assign in_ready = (count != CW'(DEPTH));
  assign do_wr    = in_valid & in_ready;

  // storage without reset so a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= in_data;
    if (rd_en) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      if (rd_en) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      case ({do_wr, rd_en})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/i2sx_stager.sv
module i2sx_stager #(
  parameter int LANES = 4,
  parameter int W     = 32,
  parameter int CW    = 5,
  localparam int NW   = 2 * LANES,
  localparam int IW   = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW-1:0]   need,
  input  logic [CW-1:0]   fifo_count,
  output logic            rd_en,
  input  logic [W-1:0]    rd_data,
  input  logic            take,
  output logic            staged,
  output logic [NW*W-1:0] stage_flat
);
  logic [W-1:0]  stage_q [NW];
  logic          gathering, cap_v;
  logic [CW-1:0] pop_cnt, cap_idx;

  assign rd_en = gathering;

  for (genvar k = 0; k < NW; k++) begin : g_flat
    assign stage_flat[k*W +: W] = stage_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gathering <= 1'b0;
      cap_v     <= 1'b0;
      pop_cnt   <= '0;
      cap_idx   <= '0;
      staged    <= 1'b0;
      for (int k = 0; k < NW; k++) stage_q[k] <= '0;
    end else begin
      // read data arrives one cycle after each pop
      cap_v   <= gathering;
      cap_idx <= pop_cnt;
      if (cap_v) begin
        stage_q[cap_idx[IW-1:0]] <= rd_data;
        if (cap_idx == need - CW'(1)) staged <= 1'b1;
      end
      if (take) staged <= 1'b0;
      if (gathering) begin
        if (pop_cnt == need - CW'(1)) begin
          gathering <= 1'b0;
          pop_cnt   <= '0;
        end else begin
          pop_cnt <= pop_cnt + CW'(1);
        end
      end else if (!staged && !cap_v && fifo_count >= need) begin
        gathering <= 1'b1;
        pop_cnt   <= '0;
      end
    end
  end
endmodule

// File: rtl/i2sx_clkgen.sv
module i2sx_clkgen import i2sx_pkg::*; #(
  parameter int HALF = 2,
  localparam int DW  = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic ws_inv,
  input  logic staged,
  output logic bclk,
  output logic ws,
  output logic running,
  output logic start,
  output logic step,
  output logic frame_start
);
  logic [DW-1:0]     div_cnt;
  logic [BIT_IW-1:0] bit_idx, nxt_bit;
  logic              half_done, fall;

  assign half_done   = (div_cnt == DW'(HALF - 1));
  assign start       = enable & ~running & staged;
  assign fall        = enable & running & half_done & bclk;
  assign step        = start | fall;
  assign frame_start = start | (fall & (bit_idx == BIT_IW'(FRAME_BITS - 1)));
  assign nxt_bit     = bit_idx + BIT_IW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      div_cnt <= '0;
      bclk    <= 1'b0;
      bit_idx <= '0;
      ws      <= 1'b0;
    end else if (!enable || !running) begin
      div_cnt <= '0;
      bclk    <= 1'b0;
      bit_idx <= '0;
      ws      <= ws_inv;
      running <= start;
    end else if (half_done) begin
      div_cnt <= '0;
      bclk    <= ~bclk;
      if (bclk) begin
        bit_idx <= nxt_bit;
        ws      <= nxt_bit[BIT_IW-1] ^ ws_inv;
      end
    end else begin
      div_cnt <= div_cnt + DW'(1);
    end
  end
endmodule

// File: rtl/i2sx_lane.sv
module i2sx_lane #(
  parameter int FW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  input  logic          load,
  input  logic [FW-1:0] frame_in,
  input  logic          i2s_mode,
  input  logic          drive,
  output logic          sd
);
  logic [FW-1:0] sr, next_sr;
  logic          bit_q, new_bit;

  assign next_sr = load ? frame_in : {sr[FW-2:0], 1'b0};
  // delayed mode repeats the bit that the previous period carried
  assign new_bit = i2s_mode ? sr[FW-1] : next_sr[FW-1];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sr    <= '0;
      bit_q <= 1'b0;
      sd    <= 1'b0;
    end else begin
      if (step) begin
        sr    <= next_sr;
        bit_q <= new_bit;
      end
      sd <= drive & (step ? new_bit : bit_q);
    end
  end
endmodule

// File: rtl/i2s_multilane_tx.sv
module i2s_multilane_tx import i2sx_pkg::*; #(
  parameter int LANES      = 4,
  parameter int FIFO_DEPTH = 16,
  parameter int BCLK_HALF  = 2,
  localparam int LW        = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  output logic             smp_ready,
  input  logic             cfg_enable,
  input  logic             cfg_data_en,
  input  logic             cfg_ws_inv,
  input  logic [LW-1:0]    cfg_lanes_m1,
  input  logic [LANES-1:0] lane_enable,
  input  logic [LANES-1:0] lane_i2s,
  output logic             bclk,
  output logic             ws,
  output logic [LANES-1:0] sd,
  output logic             underflow
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int NW = 2 * LANES;

  logic [LW-1:0]         eff_m1;
  logic [CW-1:0]         need, fifo_count;
  logic                  fifo_rd, staged;
  logic [SMP_W-1:0]      fifo_q;
  logic [NW*SMP_W-1:0]   stage_flat;
  logic                  running, start, step, frame_start;

  assign eff_m1 = (cfg_lanes_m1 > LW'(LANES - 1)) ? LW'(LANES - 1) : cfg_lanes_m1;
  assign need   = (CW'(eff_m1) << 1) + CW'(2);

  i2sx_fifo #(.W(SMP_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .in_valid(smp_valid), .in_data(smp_data), .in_ready(smp_ready),
    .rd_en(fifo_rd), .rd_data(fifo_q), .count(fifo_count)
  );

  i2sx_stager #(.LANES(LANES), .W(SMP_W), .CW(CW)) u_stage (
    .clk(clk), .rst(rst), .need(need), .fifo_count(fifo_count),
    .rd_en(fifo_rd), .rd_data(fifo_q), .take(frame_start & staged),
    .staged(staged), .stage_flat(stage_flat)
  );

  i2sx_clkgen #(.HALF(BCLK_HALF)) u_clk (
    .clk(clk), .rst(rst), .enable(cfg_enable), .ws_inv(cfg_ws_inv),
    .staged(staged), .bclk(bclk), .ws(ws), .running(running),
    .start(start), .step(step), .frame_start(frame_start)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [FRAME_BITS-1:0] frame_in;
    logic                  drive;
    assign frame_in = staged ? {stage_flat[(2*l)*SMP_W +: SMP_W],
                                stage_flat[(2*l+1)*SMP_W +: SMP_W]} : '0;
    assign drive    = cfg_data_en & lane_enable[l] & (LW'(l) <= eff_m1);
    i2sx_lane #(.FW(FRAME_BITS)) u_lane (
      .clk(clk), .rst(rst), .clear(~cfg_enable), .step(step),
      .load(frame_start), .frame_in(frame_in), .i2s_mode(lane_i2s[l]),
      .drive(drive), .sd(sd[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || start)              underflow <= 1'b0;
    else if (frame_start && !staged) underflow <= 1'b1;
  end
endmodule

// File: rtl/i2sx_chk.sv
module i2sx_chk #(
  parameter int LANES = 4,
  parameter int CW    = 5,
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_enable,
  input logic             cfg_data_en,
  input logic             smp_ready,
  input logic             bclk,
  input logic             ws,
  input logic [LANES-1:0] sd,
  input logic             underflow,
  input logic             running,
  input logic             fifo_rd,
  input logic [CW-1:0]    fifo_count
);
  // R10
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bclk && sd == '0 && !underflow));
  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_enable) |-> (!bclk && sd == '0));
  // R6
  data_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_data_en) |-> sd == '0);
  // R8
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(underflow) && $past(running)) |-> underflow);
  // R3
  ws_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (running && $past(running) && !$stable(ws)) |-> $fell(bclk));
  // R1
  no_underrun_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> fifo_count != '0);
  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(smp_ready) && !$past(fifo_rd)) |-> fifo_count == $past(fifo_count));
endmodule

bind i2s_multilane_tx i2sx_chk #(.LANES(LANES), .CW(CW), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_data_en(cfg_data_en),
  .smp_ready(smp_ready), .bclk(bclk), .ws(ws), .sd(sd), .underflow(underflow),
  .running(running), .fifo_rd(fifo_rd), .fifo_count(fifo_count)
);

// File: tb/i2s_multilane_tx_tb.sv
module i2s_multilane_tx_tb;
  localparam int LANES = 2, DEPTH = 8, HALF = 1, LW = 1, NF = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [31:0] smp_data = '0;
  logic smp_ready;
  logic cfg_enable = 1'b0, cfg_data_en = 1'b0, cfg_ws_inv = 1'b0;
  logic [LW-1:0] cfg_lanes_m1 = '0;
  logic [LANES-1:0] lane_enable = '0, lane_i2s = '0;
  logic bclk, ws, underflow;
  logic [LANES-1:0] sd;
  int n_checks = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  i2s_multilane_tx #(.LANES(LANES), .FIFO_DEPTH(DEPTH), .BCLK_HALF(HALF)) u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .cfg_enable(cfg_enable), .cfg_data_en(cfg_data_en),
    .cfg_ws_inv(cfg_ws_inv), .cfg_lanes_m1(cfg_lanes_m1),
    .lane_enable(lane_enable), .lane_i2s(lane_i2s), .bclk(bclk), .ws(ws),
    .sd(sd), .underflow(underflow)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  function automatic logic [31:0] pat(int c, int f, int k);
    return (32'h9E3779B9 * 32'(c * 256 + f * 16 + k + 1)) ^ 32'(c * 7);
  endfunction

  // left-justified bit stream of one lane, zero outside the data frames
  function automatic logic lj(int c, int l, int f, int p);
    logic [31:0] w;
    if (f < 0 || f >= NF) return 1'b0;
    w = (p < 32) ? pat(c, f, 2 * l) : pat(c, f, 2 * l + 1);
    return w[31 - (p % 32)];
  endfunction

  task automatic do_reset();
    cfg_enable = 1'b0;
    smp_valid  = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_words(int c, int need, int n);
    for (int k = 0; k < n; k++) begin
      smp_valid = 1'b1;
      smp_data  = pat(c, k / need, k % need);
      while (!smp_ready) @(negedge clk);
      @(negedge clk);
    end
    smp_valid = 1'b0;
  endtask

  task automatic run_cfg(int c, int lm1, logic [1:0] mode, logic inv,
                         logic den, logic [1:0] len);
    logic [255:0] cws;
    logic [255:0] csd [LANES];
    int need;
    need = 2 * (lm1 + 1);
    cfg_lanes_m1 = LW'(lm1);
    lane_i2s     = mode;
    cfg_ws_inv   = inv;
    cfg_data_en  = den;
    lane_enable  = len;
    do_reset();
    // R10
    chk(!bclk && sd == '0 && !underflow && smp_ready, "R10", "reset state",
        {60'd0, bclk, sd[1], underflow, smp_ready}, 64'h1);
    fork
      write_words(c, need, NF * need);
      begin
        int b;
        logic pb;
        b  = 0;
        pb = 1'b0;
        cfg_enable = 1'b1;
        while (b < 256) begin
          @(negedge clk);
          if (bclk && !pb) begin
            cws[b] = ws;
            for (int l = 0; l < LANES; l++) csd[l][b] = sd[l];
            if (b == 128) chk(underflow == 1'b0, "R8", "flag before empty frame",
                              64'(underflow), 64'h0);
            if (b == 192) chk(underflow == 1'b1, "R8", "flag on empty frame",
                              64'(underflow), 64'h1);
            b++;
          end
          pb = bclk;
        end
      end
    join
    cfg_enable = 1'b0;
    @(negedge clk);
    // R9
    chk(!bclk && sd == '0 && ws == inv, "R9", "stopped outputs",
        {61'd0, bclk, sd[0] | sd[1], ws}, {63'd0, inv});
    begin
      logic [255:0] ews;
      for (int b = 0; b < 256; b++) ews[b] = (((b % 64) >= 32) ? 1'b1 : 1'b0) ^ inv;
      // R5 R3
      chk(cws == ews, "R5 R3", $sformatf("ws pattern cfg %0d", c),
          cws[255:192], ews[255:192]);
    end
    for (int l = 0; l < LANES; l++) begin
      for (int f = 0; f <= NF; f++) begin
        logic [63:0] e, a;
        logic act;
        act = den && len[l] && (l <= lm1);
        for (int p = 0; p < 64; p++) begin
          logic v;
          if (mode[l]) v = (p == 0) ? lj(c, l, f - 1, 63) : lj(c, l, f, p - 1);
          else         v = lj(c, l, f, p);
          e[63 - p] = act & v;
          a[63 - p] = csd[l][f * 64 + p];
        end
        // R1 R2 R4 R6 R8
        chk(a == e, mode[l] ? "R1 R2 R4 R6 R8" : "R1 R2 R3 R6 R8",
            $sformatf("cfg %0d lane %0d frame %0d", c, l, f), a, e);
      end
    end
  endtask

  initial begin
    int c;
    c = 0;
    for (int lm1 = 0; lm1 < 2; lm1++)
      for (int mode = 0; mode < 4; mode++)
        for (int inv = 0; inv < 2; inv++) begin
          run_cfg(c, lm1, 2'(mode), 1'(inv), 1'b1, 2'b11);
          c++;
        end
    run_cfg(c, 1, 2'b01, 1'b0, 1'b0, 2'b11); c++;   // R6 data gated off
    run_cfg(c, 1, 2'b10, 1'b1, 1'b1, 2'b10); c++;   // R6 lane 0 disabled
    run_cfg(c, 1, 2'b01, 1'b0, 1'b1, 2'b01); c++;   // R6 lane 1 disabled
    run_cfg(c, 0, 2'b00, 1'b1, 1'b1, 2'b10); c++;   // R2 one lane, lane 1 idle

    // R1: buffer plus one staged frame fills after DEPTH + 4 words
    cfg_lanes_m1 = LW'(1);
    do_reset();
    write_words(99, 4, DEPTH + 4);
    repeat (4) @(negedge clk);
    chk(smp_ready == 1'b0, "R1", "ready when full", 64'(smp_ready), 64'h0);

    // R7: no bit clock until a frame is staged
    do_reset();
    cfg_enable = 1'b1;
    begin
      int rises;
      rises = 0;
      repeat (20) begin
        @(negedge clk);
        if (bclk) rises++;
      end
      chk(rises == 0, "R7", "clock held while unstaged", 64'(rises), 64'h0);
      write_words(77, 4, 4);
      rises = 0;
      repeat (20) begin
        @(negedge clk);
        if (bclk) rises++;
      end
      chk(rises > 0, "R7", "clock starts once staged", 64'(rises), 64'h1);
    end
    cfg_enable = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule